// File: doc/BRIEF.md
# Composite Luma/Chroma Encoder

This block turns one 8-bit color byte per clock into a 3-bit baseband level for a resistor-ladder composite video DAC. A pixel serializer presents the byte; the encoder decodes a brightness level, a modulation-enable flag and a 4-bit hue. A 4-bit phase counter runs freely at sixteen times the color subcarrier. When color is requested, the encoder moves the brightness one step up or down, following a square-wave subcarrier that is delayed by the hue.

Two control inputs shape the output. `chromaEn` allows color at all. `chromaSplit` chooses where the modulation appears. With `chromaSplit` low, the encoder adds it to the 3-bit level. With `chromaSplit` high, the level stays clean and the modulation drives a separate single-bit chroma line. Both outputs are registered.

Top module: `luma_chroma_enc`

## Requirements
- R1: While `rst_n` is low, `lumaOut` and `chromaOut` read 0 at the next clock and the phase counter returns to 0. The first clock edge with `rst_n` high uses phase 0.
- R2: The phase counter advances by one on every clock edge with `rst_n` high and wraps from 15 to 0. Each output is registered and reflects the inputs present at the previous clock edge.
- R3: If byte bit 3 (modulation enable) is 0, then `lumaOut` equals byte bits 2:0 and `chromaOut` is 0. The hue bits 7:4 have no effect in this case.
- R4: If `chromaEn` is 0, then `lumaOut` equals byte bits 2:0 and `chromaOut` is 0, whatever bits 7:4 and bit 3 hold.
- R5: If bit 3 is 1, `chromaEn` is 1 and `chromaSplit` is 0, the subcarrier sign is bit 3 of (phase + bits 7:4) mod 16. `lumaOut` equals luma+1 when that sign is 1 and luma−1 when it is 0. Over any 16 consecutive clocks at a fixed hue, the sign is high for 8 clocks and low for 8 clocks.
- R6: In the case of R5, the level saturates instead of wrapping: luma 7 with a high sign stays 7, and luma 0 with a low sign stays 0.
- R7: If bit 3 is 1, `chromaEn` is 1 and `chromaSplit` is 1, then `lumaOut` equals bits 2:0 and `chromaOut` equals the subcarrier sign defined in R5. `chromaOut` is 0 whenever `chromaSplit` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at sixteen times the color subcarrier |
| rst_n | input | 1 | Synchronous active-low reset |
| colorByte | input | 8 | Color byte: luma in bits 2:0, modulation enable in bit 3, hue in bits 7:4 |
| chromaEn | input | 1 | Allows chroma modulation |
| chromaSplit | input | 1 | 1 sends the modulation to `chromaOut`; 0 adds it to `lumaOut` |
| lumaOut | output | 3 | Registered baseband level |
| chromaOut | output | 1 | Registered separate chroma line |

## Verification
The assertions assume that the inputs are stable across each rising edge. They also assume that any cycle whose inputs they compare against was itself out of reset, which a warm-up flag in the checker tracks. The bench changes all inputs only just after a falling edge. It releases reset on a falling edge, once at the start and once in mid-run, so that the reference phase count lines up with the design's count from the first active edge. The stimulus crosses every mode combination. It sweeps the hue over all sixteen values and holds the luma at 0 and 7 long enough to meet both subcarrier signs.

// File: rtl/lce_pkg.sv
package lce_pkg;
  // strobes from the control half to the datapath half
  typedef struct packed {
    logic tweakLuma;   // apply +/-1 to the level
    logic driveLine;   // put the sign on the separate chroma line
    logic raise;       // subcarrier sign: 1 = up, 0 = down
  } modStrobe_t;
endpackage

// File: rtl/lce_ctrl.sv
module lce_ctrl
  import lce_pkg::*;
#(
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] hue,
  input  logic               modBit,
  input  logic               chromaEn,
  input  logic               chromaSplit,
  output modStrobe_t         strobe,
  output logic [PHASE_W-1:0] phaseNow
);
  logic [PHASE_W-1:0] phaseCnt;
  logic [PHASE_W-1:0] shifted;
  logic               active;

  always_ff @(posedge clk) begin
    if (!rst_n) phaseCnt <= '0;
    else        phaseCnt <= phaseCnt + 1'b1;
  end

  always_comb begin
    shifted          = phaseCnt + hue;
    active           = modBit & chromaEn;
    strobe.raise     = shifted[PHASE_W-1];
    strobe.tweakLuma = active & ~chromaSplit;
    strobe.driveLine = active & chromaSplit;
  end

  assign phaseNow = phaseCnt;
endmodule

// File: rtl/lce_datapath.sv
module lce_datapath
  import lce_pkg::*;
#(
  parameter int LUMA_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LUMA_W-1:0] lumaIn,
  input  modStrobe_t        strobe,
  output logic [LUMA_W-1:0] lumaOut,
  output logic              chromaOut
);
  localparam logic [LUMA_W-1:0] LUMA_TOP = '1;

  logic [LUMA_W-1:0] lumaNext;

  always_comb begin
    lumaNext = lumaIn;
    if (strobe.tweakLuma) begin
      if (strobe.raise) begin
        if (lumaIn != LUMA_TOP) lumaNext = lumaIn + 1'b1;
      end else begin
        if (lumaIn != '0) lumaNext = lumaIn - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lumaOut   <= '0;
      chromaOut <= 1'b0;
    end else begin
      lumaOut   <= lumaNext;
      chromaOut <= strobe.driveLine & strobe.raise;
    end
  end
endmodule

// File: rtl/luma_chroma_enc.sv
module luma_chroma_enc
  import lce_pkg::*;
#(
  parameter  int LUMA_W  = 3,
  parameter  int PHASE_W = 4,
  localparam int BYTE_W  = LUMA_W + 1 + PHASE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] colorByte,
  input  logic              chromaEn,
  input  logic              chromaSplit,
  output logic [LUMA_W-1:0] lumaOut,
  output logic              chromaOut
);
  modStrobe_t         strobe;
  logic [PHASE_W-1:0] phaseNow;

  lce_ctrl #(.PHASE_W(PHASE_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .hue        (colorByte[BYTE_W-1:LUMA_W+1]),
    .modBit     (colorByte[LUMA_W]),
    .chromaEn   (chromaEn),
    .chromaSplit(chromaSplit),
    .strobe     (strobe),
    .phaseNow   (phaseNow)
  );

  lce_datapath #(.LUMA_W(LUMA_W)) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .lumaIn   (colorByte[LUMA_W-1:0]),
    .strobe   (strobe),
    .lumaOut  (lumaOut),
    .chromaOut(chromaOut)
  );
endmodule

// File: rtl/lce_checker.sv
module lce_checker #(
  parameter int LUMA_W  = 3,
  parameter int PHASE_W = 4,
  parameter int BYTE_W  = LUMA_W + 1 + PHASE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BYTE_W-1:0] colorByte,
  input logic              chromaEn,
  input logic              chromaSplit,
  input logic [LUMA_W-1:0] lumaOut,
  input logic              chromaOut,
  input logic [PHASE_W-1:0] phaseNow
);
  logic warm;
  logic [LUMA_W:0] lumaWide;
  logic [LUMA_W:0] pastWide;

  always_ff @(posedge clk) begin
    if (!rst_n) warm <= 1'b0;
    else        warm <= 1'b1;
  end

  assign lumaWide = {1'b0, lumaOut};
  assign pastWide = {1'b0, colorByte[LUMA_W-1:0]};

  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_n |=> (lumaOut == '0 && !chromaOut));

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> phaseNow == PHASE_W'($past(phaseNow) + 1'b1));

  assert_plain_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    warm && !$past(colorByte[LUMA_W]) |->
      (lumaOut == $past(colorByte[LUMA_W-1:0]) && !chromaOut));

  assert_chroma_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    warm && !$past(chromaEn) |->
      (lumaOut == $past(colorByte[LUMA_W-1:0]) && !chromaOut));

  assert_one_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (lumaWide == $past(pastWide) ||
              lumaWide == $past(pastWide) + 1'b1 ||
              lumaWide + 1'b1 == $past(pastWide)));

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    warm && $past(colorByte[LUMA_W-1:0]) == '1 |-> lumaOut != '0);

  assert_split_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    warm && $past(chromaSplit) |-> lumaOut == $past(colorByte[LUMA_W-1:0]));

  assert_line_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    warm && !$past(chromaSplit) |-> !chromaOut);
endmodule

bind luma_chroma_enc lce_checker #(.LUMA_W(LUMA_W), .PHASE_W(PHASE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .colorByte  (colorByte),
  .chromaEn   (chromaEn),
  .chromaSplit(chromaSplit),
  .lumaOut    (lumaOut),
  .chromaOut  (chromaOut),
  .phaseNow   (phaseNow)
);

// File: tb/luma_chroma_enc_tb.sv
module luma_chroma_enc_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] colorByte = '0;
  logic       chromaEn = 1'b0;
  logic       chromaSplit = 1'b0;
  logic [2:0] lumaOut;
  logic       chromaOut;

  int checks = 0;
  int errors = 0;
  int ph = 0;

  always #5 clk = ~clk;

  luma_chroma_enc u_dut (
    .clk(clk), .rst_n(rst_n), .colorByte(colorByte),
    .chromaEn(chromaEn), .chromaSplit(chromaSplit),
    .lumaOut(lumaOut), .chromaOut(chromaOut)
  );

  task automatic check(input string tag, input int gotL, input int expL,
                       input int gotC, input int expC);
    checks++;
    if (gotL != expL || gotC != expC) begin
      errors++;
      $display("FAIL %s: luma %0d chroma %0d, expected luma %0d chroma %0d",
               tag, gotL, gotC, expL, expC);
    end
  endtask

  // R1: hold reset for n cycles, release on a falling edge
  task automatic doReset(input int n);
    rst_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      check("R1 reset", lumaOut, 0, chromaOut, 0);
    end
    rst_n = 1'b1;
    ph = 0;
  endtask

  task automatic step(input logic [7:0] b, input logic en, input logic sp);
    int l, h, eL, eC;
    bit m, up;
    string tag;
    colorByte = b; chromaEn = en; chromaSplit = sp;
    l = int'(b[2:0]); m = b[3]; h = int'(b[7:4]);
    @(posedge clk);
    up = ((ph + h) % 16) >= 8;
    ph = (ph + 1) % 16;
    eL = l; eC = 0;
    if (!m) tag = "R3 plain";
    else if (!en) tag = "R4 chroma off";
    else if (sp) begin
      tag = "R7 split R2";
      eC = up ? 1 : 0;
    end else begin
      tag = (l == 0 || l == 7) ? "R6 saturate R2" : "R5 modulate R2";
      if (up) eL = (l == 7) ? 7 : l + 1;
      else    eL = (l == 0) ? 0 : l - 1;
    end
    @(negedge clk);
    check(tag, lumaOut, eL, chromaOut, eC);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not end, expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset(3);
    // R3: modulation bit clear, hue varies
    for (int i = 0; i < 24; i++)
      step({4'(i * 5), 1'b0, 3'(i)}, i[0], i[1]);
    // R4: chroma disabled with modulation bit set
    for (int i = 0; i < 24; i++)
      step({4'(i * 3), 1'b1, 3'(i + 2)}, 1'b0, i[2]);
    // R5/R2: fixed hue, two full subcarrier periods
    for (int i = 0; i < 32; i++)
      step({4'd0, 1'b1, 3'd3}, 1'b1, 1'b0);
    // R5: hue sweep
    for (int h = 0; h < 16; h++)
      for (int i = 0; i < 16; i++)
        step({4'(h), 1'b1, 3'(1 + (i % 6))}, 1'b1, 1'b0);
    // R6: saturation at both ends
    for (int i = 0; i < 16; i++) step({4'd5, 1'b1, 3'd7}, 1'b1, 1'b0);
    for (int i = 0; i < 16; i++) step({4'd9, 1'b1, 3'd0}, 1'b1, 1'b0);
    // R7: separate chroma line, hue sweep
    for (int h = 0; h < 16; h++)
      for (int i = 0; i < 16; i++)
        step({4'(h), 1'b1, 3'(i % 8)}, 1'b1, 1'b1);
    // R1: mid-run reset restarts phase
    doReset(2);
    for (int i = 0; i < 20; i++) step({4'd0, 1'b1, 3'd4}, 1'b1, 1'b1);
    // mixed modes every cycle
    for (int i = 0; i < 64; i++)
      step(8'(i * 37 + 11), i[1], i[3]);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule